// File: doc/BRIEF.md
# Latch-Captured Dual-Port Nibble Memory

A 32-word store of 4-bit nibbles. Its write side and read side run independently. Stored bits are held in level-sensitive latches, not flip-flops. A single capture-mode input sets how the write side opens those latches.

In latch capture, the addressed nibble is open for as long as the load strobe is high and the active-low write enable is low. Incoming data appears on the read side in the same instant when the read address matches. In edge capture, a front-end latch is paired with the storage latch, and the pair acts as a flip-flop clocked by the sector clock. Write data, address and control are taken on the rising edge.

The read side is purely combinational, gated by an output enable. A build parameter selects whether a disabled output floats or returns zero. A second build parameter folds the block into a single-port memory. In that form the write address selects the word for both directions, and a bidirectional data pin carries write data in and read data out. An asynchronous clear zeroes every stored bit.

Top module: `latch_dpram`

## Requirements
- R1: Holds DEPTH (32) words of DATA_W (4) bits; a write to one address and a read from another in the same instant do not disturb each other.
- R2: With oe=1 and cap_mode=0, rd_data equals the word at raddr at all times, with no clock edge needed after raddr or contents change.
- R3: With cap_mode=0, load=1 and we_n=0, the word at waddr follows wr_data continuously, and a read of that same address returns wr_data immediately (write-through).
- R4: A word keeps its value while we_n=1, or load=0, or it is not the word selected by waddr.
- R5: With cap_mode=1, a word changes only at a rising sclk edge at which load=1 and we_n=0 held; changes of wr_data, waddr, load or we_n between edges have no effect on stored contents.
- R6: While clr=1 every word reads as zero and write attempts are ignored.
- R7: With oe=0, rd_data is zero when TRISTATE_OUT=0 and high-impedance when TRISTATE_OUT=1.
- R8: With SINGLE_PORT=1, write data is taken from bus_io, and bus_io is driven with the word at waddr only while oe=1 and we_n=1; otherwise the block leaves bus_io undriven.
- R9: With SINGLE_PORT=1, raddr and wr_data are ignored; rd_data shows the word at waddr (gated by oe).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Sector clock used for edge capture |
| clr | input | 1 | Asynchronous clear of all stored bits, active high |
| cap_mode | input | 1 | 0 = latch capture, 1 = edge capture |
| waddr | input | ADDR_W | Write address (shared address in single-port form) |
| raddr | input | ADDR_W | Read address (unused in single-port form) |
| wr_data | input | DATA_W | Write data (unused in single-port form) |
| we_n | input | 1 | Write enable, active low |
| load | input | 1 | Load strobe, active high |
| oe | input | 1 | Output enable for rd_data and bus_io |
| rd_data | output | DATA_W | Asynchronous read data |
| bus_io | inout | DATA_W | Bidirectional data pin of the single-port form |

## Verification
On every sclk edge the assertions compare rd_data against the addressed stored word, check write-through in latch capture, check that the store is all zero under clear, and check that edge capture leaves the store stable across any cycle whose sampled controls do not request a write. The bench scenarios cover what those edge samples cannot see. These are mid-cycle behaviour: data following the input while the latch is open, the front-end latch refusing changes during the high clock phase, and write attempts swallowed during clear. The bench also covers what happens at the bidirectional pin of the single-port build, including that no contention occurs while a write drives the pin.

// File: rtl/lmram_pkg.sv
package lmram_pkg;

   typedef enum logic {
      CAP_LATCH = 1'b0,
      CAP_EDGE  = 1'b1
   } cap_mode_e;

   // Clock-mux model: in edge capture the selected phase passes,
   // otherwise the mux forces a constant open level.
   function automatic logic gate_mux(input cap_mode_e mode, input logic phase);
      return (mode == CAP_EDGE) ? phase : 1'b1;
   endfunction

endpackage

// File: rtl/lmram_front.sv
module lmram_front
   import lmram_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 4,
   parameter int DEPTH  = 32
) (
   input  logic              sclk,
   input  logic              cap_mode,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] din,
   input  logic              load,
   input  logic              we_n,
   output logic [DEPTH-1:0]  cell_gate,
   output logic [DATA_W-1:0] f_din
);

   cap_mode_e         mode;
   logic              fe_open;
   logic              st_open;
   logic [ADDR_W-1:0] f_addr;
   logic              f_load;
   logic              f_wen;

   assign mode    = cap_mode_e'(cap_mode);
   // both muxes share one select: open-low front, open-high storage
   assign fe_open = gate_mux(mode, ~sclk);
   assign st_open = gate_mux(mode, sclk);

   always_latch begin
      if (fe_open) begin
         f_addr <= waddr;
         f_din  <= din;
         f_load <= load;
         f_wen  <= we_n;
      end
   end

   for (genvar w = 0; w < DEPTH; w++) begin : g_dec
      assign cell_gate[w] = st_open & f_load & ~f_wen
                            & (f_addr == ADDR_W'(w));
   end

endmodule

// File: rtl/lmram_cell.sv
module lmram_cell #(
   parameter int DATA_W = 4
) (
   input  logic              clr,
   input  logic              gate,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   always_latch begin
      if (clr)       q <= '0;
      else if (gate) q <= d;
   end

endmodule

// File: rtl/lmram_rdport.sv
module lmram_rdport #(
   parameter int ADDR_W       = 5,
   parameter int DATA_W       = 4,
   parameter int DEPTH        = 32,
   parameter bit TRISTATE_OUT = 1'b0
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic [DEPTH*DATA_W-1:0] words_flat,
   input  logic                    oe,
   output logic [DATA_W-1:0]       rd
);

   localparam int SLOTS = 2 ** ADDR_W;

   logic [DATA_W-1:0] slot [SLOTS];
   logic [DATA_W-1:0] word;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i < DEPTH) begin : g_used
         assign slot[i] = words_flat[i*DATA_W +: DATA_W];
      end else begin : g_empty
         assign slot[i] = '0;
      end
   end

   assign word = slot[addr];

   if (TRISTATE_OUT) begin : g_float
      assign rd = oe ? word : {DATA_W{1'bz}};
   end else begin : g_zero
      assign rd = oe ? word : '0;
   end

endmodule

// File: rtl/latch_dpram.sv
module latch_dpram
   import lmram_pkg::*;
#(
   parameter int ADDR_W       = 5,
   parameter int DATA_W       = 4,
   parameter int DEPTH        = 32,
   parameter bit SINGLE_PORT  = 1'b0,
   parameter bit TRISTATE_OUT = 1'b0
) (
   input  logic              sclk,
   input  logic              clr,
   input  logic              cap_mode,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [ADDR_W-1:0] raddr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              we_n,
   input  logic              load,
   input  logic              oe,
   output logic [DATA_W-1:0] rd_data,
   inout  wire  [DATA_W-1:0] bus_io
);

   localparam int FLAT_W = DEPTH * DATA_W;

   if (DATA_W < 1) begin : g_bad_width
      $error("latch_dpram: DATA_W must be at least 1");
   end
   if (DEPTH < 2 || DEPTH > 2 ** ADDR_W) begin : g_bad_depth
      $error("latch_dpram: DEPTH must lie in 2 .. 2**ADDR_W");
   end

   logic [DATA_W-1:0] din_sel;
   logic [ADDR_W-1:0] rd_addr;
   logic [DEPTH-1:0]  cell_gate;
   logic [DATA_W-1:0] f_din;
   logic [FLAT_W-1:0] words_flat;
   logic [DATA_W-1:0] rd_word;

   if (SINGLE_PORT) begin : g_sp
      assign din_sel = bus_io;
      assign rd_addr = waddr;
      // drive the pin only when no write is requested
      assign bus_io  = (oe && we_n) ? rd_word : {DATA_W{1'bz}};
   end else begin : g_dp
      assign din_sel = wr_data;
      assign rd_addr = raddr;
      assign bus_io  = {DATA_W{1'bz}};
   end

   lmram_front #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_front (
      .sclk      (sclk),
      .cap_mode  (cap_mode),
      .waddr     (waddr),
      .din       (din_sel),
      .load      (load),
      .we_n      (we_n),
      .cell_gate (cell_gate),
      .f_din     (f_din)
   );

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      lmram_cell #(
         .DATA_W (DATA_W)
      ) u_cell (
         .clr  (clr),
         .gate (cell_gate[w]),
         .d    (f_din),
         .q    (words_flat[w*DATA_W +: DATA_W])
      );
   end

   // internal copy is always enabled; the pin gating happens above
   lmram_rdport #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .DEPTH        (DEPTH),
      .TRISTATE_OUT (1'b0)
   ) u_rd_int (
      .addr       (rd_addr),
      .words_flat (words_flat),
      .oe         (1'b1),
      .rd         (rd_word)
   );

   lmram_rdport #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .DEPTH        (DEPTH),
      .TRISTATE_OUT (TRISTATE_OUT)
   ) u_rd_out (
      .addr       (rd_addr),
      .words_flat (words_flat),
      .oe         (oe),
      .rd         (rd_data)
   );

endmodule

// File: rtl/latch_dpram_chk.sv
module latch_dpram_chk #(
   parameter int ADDR_W       = 5,
   parameter int DATA_W       = 4,
   parameter int DEPTH        = 32,
   parameter bit SINGLE_PORT  = 1'b0,
   parameter bit TRISTATE_OUT = 1'b0
) (
   input logic                    sclk,
   input logic                    clr,
   input logic                    cap_mode,
   input logic [ADDR_W-1:0]       waddr,
   input logic [ADDR_W-1:0]       raddr,
   input logic [DATA_W-1:0]       wr_data,
   input logic                    we_n,
   input logic                    load,
   input logic                    oe,
   input logic [DATA_W-1:0]       rd_data,
   input logic [DEPTH*DATA_W-1:0] words_flat
);

   // R6: clear forces the whole store to zero
   assert_clear_zero_R6: assert property (@(posedge sclk)
      clr |-> (words_flat == '0));

   // R5: edge capture without a sampled write request leaves the store stable
   assert_edge_hold_R5: assert property (@(posedge sclk) disable iff (clr)
      (cap_mode && $past(cap_mode) && !$past(clr)
       && $past(!(load && !we_n))) |-> $stable(words_flat));

   if (!SINGLE_PORT && DEPTH == 2 ** ADDR_W) begin : g_dp_checks
      // R2: the output shows the stored word at the read address
      assert_read_word_R2: assert property (@(posedge sclk) disable iff (clr)
         (oe && !cap_mode && (we_n || !load || waddr != raddr))
         |-> (rd_data == words_flat[int'(raddr)*DATA_W +: DATA_W]));

      // R3: latch capture passes write data straight to a matching read
      assert_write_through_R3: assert property (@(posedge sclk) disable iff (clr)
         (!cap_mode && load && !we_n && oe && waddr == raddr)
         |-> (rd_data == wr_data));
   end

   if (!TRISTATE_OUT) begin : g_zero_checks
      // R7: disabled output reads as zero in the internal-bus variant
      assert_oe_zero_R7: assert property (@(posedge sclk) disable iff (clr)
         !oe |-> (rd_data == '0));
   end

endmodule

bind latch_dpram latch_dpram_chk #(
   .ADDR_W       (ADDR_W),
   .DATA_W       (DATA_W),
   .DEPTH        (DEPTH),
   .SINGLE_PORT  (SINGLE_PORT),
   .TRISTATE_OUT (TRISTATE_OUT)
) u_chk (
   .sclk       (sclk),
   .clr        (clr),
   .cap_mode   (cap_mode),
   .waddr      (waddr),
   .raddr      (raddr),
   .wr_data    (wr_data),
   .we_n       (we_n),
   .load       (load),
   .oe         (oe),
   .rd_data    (rd_data),
   .words_flat (words_flat)
);

// File: tb/test_latch_dpram.sv
module test_latch_dpram;

   logic       sclk = 1'b0;
   logic       clr;
   logic       cap_mode;
   logic [4:0] waddr;
   logic [4:0] raddr;
   logic [3:0] wr_data;
   logic       we_n;
   logic       load;
   logic       oe;
   logic [3:0] rd_data;
   logic [3:0] sp_rd;
   wire  [3:0] dp_bus;
   wire  [3:0] sp_bus;
   logic [3:0] sp_drv;
   logic       sp_drv_en;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   logic [3:0] exp_mem [32];

   assign sp_bus = sp_drv_en ? sp_drv : 4'bzzzz;

   always #5 sclk = ~sclk;

   latch_dpram i_latch_dpram (
      .sclk (sclk), .clr (clr), .cap_mode (cap_mode), .waddr (waddr),
      .raddr (raddr), .wr_data (wr_data), .we_n (we_n), .load (load),
      .oe (oe), .rd_data (rd_data), .bus_io (dp_bus)
   );

   latch_dpram #(.SINGLE_PORT (1'b1), .TRISTATE_OUT (1'b1)) i_latch_dpram_sp (
      .sclk (sclk), .clr (clr), .cap_mode (cap_mode), .waddr (waddr),
      .raddr (raddr), .wr_data (wr_data), .we_n (we_n), .load (load),
      .oe (oe), .rd_data (sp_rd), .bus_io (sp_bus)
   );

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tw(input logic [4:0] a, input logic [3:0] d);
      we_n = 1'b1; waddr = a; wr_data = d; load = 1'b1; #1;
      we_n = 1'b0; #1;
      we_n = 1'b1; #1;
      exp_mem[a] = d;
   endtask

   task automatic t_reset();
      clr = 1'b1; cap_mode = 1'b0; we_n = 1'b1; load = 1'b0; oe = 1'b1;
      waddr = '0; raddr = '0; wr_data = '0; sp_drv = '0; sp_drv_en = 1'b0;
      repeat (2) @(negedge sclk);
      for (int i = 0; i < 32; i++) begin
         raddr = 5'(i); #1;
         check("R6 reset", rd_data, 4'h0);
         exp_mem[i] = 4'h0;
      end
      clr = 1'b0; #1;
   endtask

   task automatic t_transparent();
      raddr = 5'd5; waddr = 5'd5; wr_data = 4'hA; load = 1'b1; we_n = 1'b0; #1;
      check("R3 write-through", rd_data, 4'hA);
      wr_data = 4'h3; #1;
      check("R3 follows input", rd_data, 4'h3);
      we_n = 1'b1; #1; wr_data = 4'hF; #1;
      check("R4 hold we_n=1", rd_data, 4'h3);
      load = 1'b0; we_n = 1'b0; wr_data = 4'h6; #1;
      check("R4 hold load=0", rd_data, 4'h3);
      we_n = 1'b1; #1;
      exp_mem[5] = 4'h3;
   endtask

   task automatic t_fill_independent();
      for (int i = 0; i < 32; i++) tw(5'(i), 4'((i * 7 + 3) & 15));
      raddr = 5'd20; waddr = 5'd10; wr_data = 4'h0; load = 1'b1; we_n = 1'b0; #1;
      check("R1 read during write", rd_data, exp_mem[20]);
      we_n = 1'b1; #1; exp_mem[10] = 4'h0;
      for (int i = 0; i < 32; i++) begin
         raddr = 5'(i); #1;
         check("R2 async read sweep", rd_data, exp_mem[i]);
      end
   endtask

   task automatic t_oe();
      raddr = 5'd9; oe = 1'b0; #1;
      check("R7 oe low zero", rd_data, 4'h0);
      oe = 1'b1; #1;
      check("R7 oe restore", rd_data, exp_mem[9]);
   endtask

   task automatic t_edge();
      we_n = 1'b1; cap_mode = 1'b1;
      @(negedge sclk); #1;
      raddr = 5'd7; waddr = 5'd7; wr_data = 4'h9; load = 1'b1; we_n = 1'b0; #1;
      check("R5 no change before edge", rd_data, exp_mem[7]);
      @(posedge sclk); #1;
      check("R5 captured at edge", rd_data, 4'h9);
      wr_data = 4'h2; #1;
      check("R5 high phase ignored", rd_data, 4'h9);
      @(negedge sclk); #1;
      check("R5 low phase no write", rd_data, 4'h9);
      we_n = 1'b1; wr_data = 4'h4;
      @(posedge sclk); #1;
      check("R4 edge we_n=1 hold", rd_data, 4'h9);
      @(negedge sclk); #1; load = 1'b0; we_n = 1'b0;
      @(posedge sclk); #1;
      check("R4 edge load=0 hold", rd_data, 4'h9);
      raddr = 5'd8; #1;
      check("R4 other word untouched", rd_data, exp_mem[8]);
      we_n = 1'b1; exp_mem[7] = 4'h9;
      @(negedge sclk); #1; cap_mode = 1'b0; #1;
   endtask

   task automatic t_clear();
      clr = 1'b1; #1;
      raddr = 5'd3; waddr = 5'd3; wr_data = 4'hF; load = 1'b1; we_n = 1'b0; #1;
      check("R6 write ignored in clear", rd_data, 4'h0);
      we_n = 1'b1; #1;
      raddr = 5'd30; #1;
      check("R6 cleared word", rd_data, 4'h0);
      clr = 1'b0; #1;
      check("R6 stays zero after clear", rd_data, 4'h0);
   endtask

   task automatic t_single();
      oe = 1'b0; waddr = 5'd12; sp_drv = 4'h6; sp_drv_en = 1'b1; load = 1'b1; #1;
      we_n = 1'b0; #1; we_n = 1'b1; #1;
      sp_drv_en = 1'b0; oe = 1'b1; #1;
      check("R8 bus carries stored word", sp_bus, 4'h6);
      check("R8 rd_data single-port", sp_rd, 4'h6);
      raddr = 5'd0; wr_data = 4'hF; #1;
      check("R9 raddr ignored", sp_rd, 4'h6);
      waddr = 5'd13; sp_drv = 4'h9; sp_drv_en = 1'b1; we_n = 1'b0; #1;
      check("R8 no contention while writing", sp_bus, 4'h9);
      we_n = 1'b1; #1; sp_drv_en = 1'b0; #1;
      check("R9 wr_data ignored", sp_bus, 4'h9);
   endtask

   initial begin
      t_reset();
      t_transparent();
      t_fill_independent();
      t_oe();
      t_edge();
      t_clear();
      t_single();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule